// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block collects interrupt events from two PHY ports, six general-purpose input lines, a 16-bit down-counting timer, a software request and a power-on readiness source, and condenses them into one registered, active-high interrupt output. Each source is first qualified by its own local enable. The PHY ports use a per-event mask. The input lines use a per-line enable. The timer uses its run enable. The result lands in a sticky summary status register. That register is then gated by a summary enable register and by one global output enable.

Software reaches every register over a simple synchronous bus. It has a write strobe, a read strobe, a 3-bit address, 16-bit write data and combinational read data. Sticky status bits are cleared by writing 1 to them. Writing 0 to a status bit leaves it unchanged. If a new event arrives in the same cycle as a clear, the event wins.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every register reads 0 except the timer count (address 7), which reads FFFFh, and irq_out is 0.
- R2: Summary status bit 5 (ready, address 0) becomes 1 on the 16th rising clock edge after reset is released, is 0 before that edge, and clears on a write of 1.
- R3: A rising edge on gpio_in[i] sets bit i of the line register (address 3, status in bits [5:0]) whatever the line's enable; a falling edge sets nothing; writing 1 to bit i clears it.
- R4: Summary status bit 2 (address 0) is 1 exactly when some line status bit is set and its enable bit (address 3, bits [13:8], bit 8+i for line i) is set; writes to summary bit 2 have no effect.
- R5: An event pulse on phy_evt bit j of port p (port 0 bits [7:0], port 1 bits [15:8]) sets summary status bit p only when bit j of that port's mask register (address 4 for port 0, address 5 for port 1) is 1.
- R6: With timer enable (address 6, bit 0) set, each tmr_tick decrements the count at address 7. A tick at count 0 reloads FFFFh and sets summary status bit 3. With the enable clear, ticks change nothing. A write to address 7 loads the count.
- R7: Writing a 1 to summary enable bit 4 (address 1) sets summary status bit 4 (software request).
- R8: Summary status bits 0, 1, 3, 4 and 5 are sticky: writing 0 keeps them, and writing 1 clears them. An event in the same cycle as a clear of the same bit leaves the bit at 1.
- R9: irq_out is registered. One cycle after the registers change, it is 1 exactly when the global enable (address 2, bit 0) is 1 and some summary status bit has its summary enable bit (address 1, same position) set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, 0 when bus_rd is low |
| phy_evt | input | 16 | PHY event pulses, port 0 in [7:0], port 1 in [15:8] |
| gpio_in | input | 6 | Asynchronous general-purpose lines |
| tmr_tick | input | 1 | Timer count tick |
| irq_out | output | 1 | Aggregated interrupt request, active high |

## Verification
A lost or stuck sticky bit shows up in the summary status readback on the next read, and at irq_out one cycle later, provided the matching enables are set. A wrong mask or line-enable path shows up as a summary bit that disagrees with the event and mask pattern that was just applied. A timer count that is off by one moves the wrap flag by one tick, so the bench checks the count and the flag around the wrap tick. A ready counter that is off by one is caught at the 15th and 16th edges after reset.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int NUM_PHY = 2;
    localparam int TOP_W   = 6;
    localparam int B_PHY0  = 0;
    localparam int B_PHY1  = 1;
    localparam int B_GPIO  = 2;
    localparam int B_TMR   = 3;
    localparam int B_SW    = 4;
    localparam int B_RDY   = 5;
    localparam int GEN_OFS = 8;

    typedef enum logic [2:0] {
        A_STS  = 3'd0,
        A_EN   = 3'd1,
        A_CFG  = 3'd2,
        A_GPIO = 3'd3,
        A_MSK0 = 3'd4,
        A_MSK1 = 3'd5,
        A_TCFG = 3'd6,
        A_TCNT = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/irq_agg_line_sync.sv
module irq_agg_line_sync #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] rise
);
    for (genvar i = 0; i < N; i++) begin : g_line
        logic [2:0] sh_q;
        logic [2:0] sh_d;
        always_comb sh_d = {sh_q[1:0], pin[i]};
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= sh_d;
        end
        assign rise[i] = sh_q[1] & ~sh_q[2];
    end
endmodule

// File: rtl/irq_agg_ready.sv
module irq_agg_ready #(
    parameter int DELAY = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic fire
);
    localparam int CW = $clog2(DELAY + 1);
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != CW'(DELAY)) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign fire = (cnt_q == CW'(DELAY - 1));

    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CW'(DELAY)) |=> (cnt_q == CW'(DELAY))); // R2
endmodule

// File: rtl/irq_agg_timer.sv
module irq_agg_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        wrap  = 1'b0;
        if (load) begin
            cnt_d = load_val;
        end else if (en && tick) begin
            cnt_d = cnt_q - 1'b1;
            wrap  = (cnt_q == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '1;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    AST_TMR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
    parameter int DATA_W    = 16,
    parameter int N_GPIO    = 6,
    parameter int PHY_W     = 8,
    parameter int TMR_W     = 16,
    parameter int RDY_DELAY = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_wr,
    input  logic                           bus_rd,
    input  logic [2:0]                     bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    input  logic [irq_agg_pkg::NUM_PHY*PHY_W-1:0] phy_evt,
    input  logic [N_GPIO-1:0]              gpio_in,
    input  logic                           tmr_tick,
    output logic                           irq_out
);
    import irq_agg_pkg::*;

    typedef struct packed {
        logic [TOP_W-1:0]  sts;
        logic [TOP_W-1:0]  en;
        logic              irq_en;
        logic [N_GPIO-1:0] g_sts;
        logic [N_GPIO-1:0] g_en;
        logic [PHY_W-1:0]  msk0;
        logic [PHY_W-1:0]  msk1;
        logic              t_en;
        logic              irq;
    } state_t;

    state_t q, d;

    logic [N_GPIO-1:0] g_rise;
    logic              rdy_fire;
    logic              tmr_wrap;
    logic [TMR_W-1:0]  tmr_cnt;
    logic              wr_sts, wr_en, wr_cfg, wr_gpio, wr_m0, wr_m1, wr_tcfg, wr_tcnt;
    logic [TOP_W-1:0]  set_v, clr_v;
    logic [N_GPIO-1:0] g_clr;

    irq_agg_line_sync #(.N(N_GPIO)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(gpio_in), .rise(g_rise)
    );

    irq_agg_ready #(.DELAY(RDY_DELAY)) u_rdy (
        .clk(clk), .rst_n(rst_n), .fire(rdy_fire)
    );

    irq_agg_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .en(q.t_en), .tick(tmr_tick),
        .load(wr_tcnt), .load_val(bus_wdata[TMR_W-1:0]),
        .cnt(tmr_cnt), .wrap(tmr_wrap)
    );

    always_comb begin
        wr_sts  = bus_wr && (bus_addr == A_STS);
        wr_en   = bus_wr && (bus_addr == A_EN);
        wr_cfg  = bus_wr && (bus_addr == A_CFG);
        wr_gpio = bus_wr && (bus_addr == A_GPIO);
        wr_m0   = bus_wr && (bus_addr == A_MSK0);
        wr_m1   = bus_wr && (bus_addr == A_MSK1);
        wr_tcfg = bus_wr && (bus_addr == A_TCFG);
        wr_tcnt = bus_wr && (bus_addr == A_TCNT);

        d = q;

        clr_v = wr_sts ? bus_wdata[TOP_W-1:0] : '0;
        clr_v[B_GPIO] = 1'b0;
        set_v = '0;
        set_v[B_PHY0] = |(phy_evt[PHY_W-1:0] & q.msk0);
        set_v[B_PHY1] = |(phy_evt[2*PHY_W-1:PHY_W] & q.msk1);
        set_v[B_TMR]  = tmr_wrap;
        set_v[B_SW]   = wr_en && bus_wdata[B_SW];
        set_v[B_RDY]  = rdy_fire;
        d.sts = (q.sts & ~clr_v) | set_v;
        d.sts[B_GPIO] = |(q.g_sts & q.g_en);

        g_clr   = wr_gpio ? bus_wdata[N_GPIO-1:0] : '0;
        d.g_sts = (q.g_sts & ~g_clr) | g_rise;

        if (wr_en)   d.en     = bus_wdata[TOP_W-1:0];
        if (wr_cfg)  d.irq_en = bus_wdata[0];
        if (wr_gpio) d.g_en   = bus_wdata[GEN_OFS +: N_GPIO];
        if (wr_m0)   d.msk0   = bus_wdata[PHY_W-1:0];
        if (wr_m1)   d.msk1   = bus_wdata[PHY_W-1:0];
        if (wr_tcfg) d.t_en   = bus_wdata[0];

        d.irq = q.irq_en && |(q.sts & q.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                A_STS:   bus_rdata[TOP_W-1:0]  = q.sts;
                A_EN:    bus_rdata[TOP_W-1:0]  = q.en;
                A_CFG:   bus_rdata[0]          = q.irq_en;
                A_GPIO: begin
                    bus_rdata[N_GPIO-1:0]          = q.g_sts;
                    bus_rdata[GEN_OFS +: N_GPIO]   = q.g_en;
                end
                A_MSK0:  bus_rdata[PHY_W-1:0]  = q.msk0;
                A_MSK1:  bus_rdata[PHY_W-1:0]  = q.msk1;
                A_TCFG:  bus_rdata[0]          = q.t_en;
                A_TCNT:  bus_rdata[TMR_W-1:0]  = tmr_cnt;
                default: bus_rdata = '0;
            endcase
        end
    end

    assign irq_out = q.irq;

    AST_READY_FROM_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.sts[B_RDY]) |-> $past(rdy_fire)); // R2
    AST_PHY0_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.sts[B_PHY0] && ((phy_evt[PHY_W-1:0] & q.msk0) == '0)) |=> !q.sts[B_PHY0]); // R5
    AST_TMR_WRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_wrap |=> (q.sts[B_TMR] && (tmr_cnt == '1))); // R6
    AST_SW_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_wdata[B_SW]) |=> q.sts[B_SW]); // R7
    AST_STICKY_SW: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sts[B_SW] && !(wr_sts && bus_wdata[B_SW])) |=> q.sts[B_SW]); // R8
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !q.irq_en |=> !irq_out); // R9
endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] phy_evt = '0;
    logic [5:0]  gpio_in = '0;
    logic        tmr_tick = 1'b0;
    logic        irq_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_aggregator dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .phy_evt(phy_evt), .gpio_in(gpio_in), .tmr_tick(tmr_tick), .irq_out(irq_out)
    );

    function automatic logic exp_phy(input logic [7:0] evt, input logic [7:0] msk);
        return |(evt & msk);
    endfunction

    function automatic logic exp_gsum(input logic [5:0] s, input logic [5:0] e);
        return |(s & e);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        v = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic tick;
        @(negedge clk); tmr_tick = 1'b1;
        @(negedge clk); tmr_tick = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd24681));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values and R2 ready timing
        repeat (15) @(negedge clk);
        rd(3'd0, v); check("R2 ready before 16th edge", v, 16'h0000);
        rd(3'd7, v); check("R1 timer count reset", v, 16'hFFFF);
        rd(3'd3, v); check("R1 gpio reg reset", v, 16'h0000);
        check("R1 irq_out reset", {15'd0, irq_out}, 16'h0000);
        @(negedge clk);
        rd(3'd0, v); check("R2 ready at 16th edge", v, 16'h0020);
        rd(3'd1, v); check("R1 enable reset", v, 16'h0000);

        // R9 irq gating
        wr(3'd1, 16'h0020);
        repeat (2) @(negedge clk);
        check("R9 irq off without global enable", {15'd0, irq_out}, 16'h0000);
        wr(3'd2, 16'h0001);
        repeat (2) @(negedge clk);
        check("R9 irq on", {15'd0, irq_out}, 16'h0001);
        wr(3'd0, 16'h0000);
        rd(3'd0, v); check("R8 write 0 keeps ready", v, 16'h0020);
        wr(3'd0, 16'h0020);
        rd(3'd0, v); check("R2 ready cleared by W1C", v, 16'h0000);
        repeat (2) @(negedge clk);
        check("R9 irq drops", {15'd0, irq_out}, 16'h0000);

        // R7 software request
        wr(3'd1, 16'h0010);
        rd(3'd0, v); check("R7 sw request sets", v, 16'h0010);
        @(negedge clk);
        @(negedge clk);
        check("R9 irq from sw request", {15'd0, irq_out}, 16'h0001);
        wr(3'd0, 16'h0010);
        wr(3'd1, 16'h0000);
        rd(3'd0, v); check("R7 sw cleared, enable write 0 no set", v, 16'h0000);

        // R8 set wins over clear
        wr(3'd4, 16'h0001);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 16'h0001; phy_evt = 16'h0001;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; phy_evt = '0;
        rd(3'd0, v); check("R8 set beats clear", v, 16'h0001);
        wr(3'd0, 16'h0001);
        rd(3'd0, v); check("R8 clear", v, 16'h0000);

        // R5 random masks and events
        for (int it = 0; it < 30; it++) begin
            logic [7:0] m, e;
            int p;
            p = it % 2;
            m = 8'($urandom());
            e = 8'($urandom());
            if (it < 2) m = 8'h00;
            wr(3'(4 + p), {8'd0, m});
            wr(3'd0, 16'h0003);
            @(negedge clk);
            phy_evt = (p == 0) ? {8'd0, e} : {e, 8'd0};
            @(negedge clk);
            phy_evt = '0;
            rd(3'd0, v);
            check("R5 phy mask", {15'd0, v[p]}, {15'd0, exp_phy(e, m)});
        end
        wr(3'd0, 16'h0003);

        // R3 falling edge, R4 summary with random enables
        for (int it = 0; it < 20; it++) begin
            logic [5:0] en, pins;
            en = 6'($urandom());
            pins = 6'($urandom());
            wr(3'd3, {2'd0, en, 2'd0, 6'h3F});
            gpio_in = pins;
            repeat (4) @(negedge clk);
            rd(3'd3, v);
            check("R3 line status on rise", v, {2'd0, en, 2'd0, pins});
            @(negedge clk);
            rd(3'd0, v);
            check("R4 summary", {15'd0, v[2]}, {15'd0, exp_gsum(pins, en)});
            wr(3'd0, 16'h0004);
            rd(3'd0, v);
            check("R4 summary write ignored", {15'd0, v[2]}, {15'd0, exp_gsum(pins, en)});
            wr(3'd3, {2'd0, en, 2'd0, 6'h3F});
            gpio_in = '0;
            repeat (4) @(negedge clk);
            rd(3'd3, v);
            check("R3 fall sets nothing", v, {2'd0, en, 8'd0});
        end
        wr(3'd3, 16'h0000);

        // R6 timer
        wr(3'd7, 16'h0002);
        tick();
        rd(3'd7, v); check("R6 disabled tick ignored", v, 16'h0002);
        wr(3'd6, 16'h0001);
        tick();
        rd(3'd7, v); check("R6 decrement", v, 16'h0001);
        tick();
        rd(3'd0, v); check("R6 no flag at zero", {15'd0, v[3]}, 16'h0000);
        tick();
        rd(3'd7, v); check("R6 wrap to FFFF", v, 16'hFFFF);
        rd(3'd0, v); check("R6 wrap flag", {15'd0, v[3]}, 16'h0001);
        wr(3'd0, 16'h0008);
        rd(3'd0, v); check("R6 flag cleared", {15'd0, v[3]}, 16'h0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule